// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block keeps the control byte of an I2C interface and turns its start and stop request bits into conditions on the bus. Software never writes the byte directly. One write port sets every bit written as 1, and a second port clears every bit written as 1. The byte is read back on a read port. Three internal flags follow the bus: whether the bus is busy, whether this interface owns it, and where the current condition sequence stands. SCL and SDA are driven as open-drain pull-down enables.

All bus timing comes from one half-period count, which is an input in clock cycles. A start request on a free bus is served at once. On a busy bus the request waits for a stop condition, then waits one further half period before the start. A request made while the interface owns the bus produces a repeated start. Setting start and stop together gives a stop followed by a start when the interface is master. When it is not master, the same request gives only an internal stop. After each completed start, the interrupt flag is set and the bus is held with SCL low until software clears that flag.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, neither line is pulled, `is_master` is 0 and `bus_busy` is 0.
- R2: The control byte holds ack-enable at bit 2, interrupt flag at bit 3, stop request at bit 4, start request at bit 5 and interface enable at bit 6. A set-port write makes every bit written as 1 read 1 on the next cycle and leaves bits written as 0 unchanged.
- R3: A clear-port write makes every bit written as 1 read 0 on the next cycle. When the set port and the clear port address the same bit in the same cycle, the clear wins. The one exception is a hardware set of the interrupt flag.
- R4: Bits 0, 1 and 7 always read 0, whatever is written to either port.
- R5: While bit 6 is 0, the bus inputs are ignored (`bus_busy` stays 0), the stop bit reads 0, and no line is pulled. `is_master` stays 0 even with the start bit set.
- R6: `bus_busy` rises one cycle after SDA falls while SCL is high. It falls one cycle after SDA rises while SCL is high.
- R7: With bit 6 = 1, bit 3 = 0, no ownership and a free bus, setting bit 5 pulls SDA two cycles after the write cycle while SCL stays released. SDA is held alone for H cycles, where H is `half_period` (0 counts as 1). SCL is then pulled, and `is_master` is 1 while any line is pulled.
- R8: If bit 5 is set while the bus is busy, nothing is driven until a stop condition is seen. SDA is then pulled H+2 cycles after the stop's SDA rise reaches the inputs.
- R9: Completing a start sets bit 3. While bit 3 is 1, SCL stays pulled, SDA stays released and no further condition is produced.
- R10: While the interface owns the bus with bit 3 = 0 and bit 5 = 1, a repeated start follows. SDA is released with SCL pulled for H cycles after the step. Both lines are then released for H cycles, then SDA alone is pulled for H cycles.
- R11: While the interface owns the bus with bit 3 = 0 and bit 4 = 1, a stop follows. Both lines are pulled for H cycles, then SDA alone for H cycles, then both are released. Bit 4 clears and ownership ends H cycles after the release.
- R12: With bits 4 and 5 both set while owning the bus, the stop of R11 runs first. A new start then pulls SDA H+1 cycles after the stop's release.
- R13: With bit 4 set while the interface is not master (and bit 3 = 0), bit 4 clears on the next cycle with nothing driven on either line. A start request set in the same write is served on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_we | input | 1 | Set-port write strobe |
| set_data | input | 8 | Bits to set |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 8 | Bits to clear |
| half_period | input | CNT_W | Half bus period in clock cycles |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| ctrl_rdata | output | 8 | Control byte read-back |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| is_master | output | 1 | Interface owns the bus |
| bus_busy | output | 1 | A start has been seen without a following stop |

## Verification
Register writes show on the read port one cycle after the write edge. A start on a free bus pulls SDA on the second edge. A deferred start pulls SDA H+2 cycles after the releasing stop. Each line phase of a start, repeated start or stop lasts exactly H cycles, and a start follows a combined stop after H+1 cycles. The bench drives every input on the falling clock edge and samples on falling edges. It counts falling edges from the write or line change that launched a phase until the phase ends, so every duration is compared exactly against H (run with H = 4 and H = 3). An open-drain bus model combines the block's pull-downs with those of a second, scripted master.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int CTL_W = 8;

    // bit positions inside the control byte
    localparam int B_AA  = 2;
    localparam int B_SI  = 3;
    localparam int B_STO = 4;
    localparam int B_STA = 5;
    localparam int B_EN  = 6;

    // bits that exist as storage; the rest read as zero
    localparam logic [CTL_W-1:0] CTL_IMPL = 8'h7C;

    // control bits the sequencer acts on
    typedef struct packed {
        logic en;
        logic sta;
        logic sto;
        logic si;
    } ctl_t;

    typedef enum logic [3:0] {
        SQ_IDLE,     // not master, nothing pending
        SQ_WAIT,     // start pending, bus busy
        SQ_DELAY,    // bus just freed, half-period wait
        SQ_START,    // SDA low, SCL released
        SQ_OWN,      // holding bus: SCL low
        SQ_RS_REL,   // repeated start: release SDA, SCL low
        SQ_RS_HI,    // repeated start: both released
        SQ_STP_LO,   // stop: both low
        SQ_STP_HI,   // stop: SCL released, SDA low
        SQ_STP_END   // stop: both released, bus-free time
    } seq_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pin_drv_t;

    function automatic ctl_t ctl_view(input logic [CTL_W-1:0] r);
        ctl_t c;
        c.en  = r[B_EN];
        c.sta = r[B_STA];
        c.sto = r[B_STO];
        c.si  = r[B_SI];
        return c;
    endfunction

    function automatic pin_drv_t drive_for(input seq_t s);
        pin_drv_t d;
        d = '{scl_low: 1'b0, sda_low: 1'b0};
        case (s)
            SQ_START:  d.sda_low = 1'b1;
            SQ_OWN:    d.scl_low = 1'b1;
            SQ_RS_REL: d.scl_low = 1'b1;
            SQ_STP_LO: begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
            SQ_STP_HI: d.sda_low = 1'b1;
            default:   d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic owns_bus(input seq_t s);
        return !(s == SQ_IDLE || s == SQ_WAIT || s == SQ_DELAY);
    endfunction

endpackage

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
    import i2c_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic [CTL_W-1:0] set_data,
    input  logic             clr_we,
    input  logic [CTL_W-1:0] clr_data,
    input  logic             si_hw_set,
    input  logic             sto_hw_clr,
    output logic [CTL_W-1:0] rdata,
    output ctl_t             ctl
);

    logic [CTL_W-1:0] raw_q;
    logic [CTL_W-1:0] raw_d;

    always_comb begin
        raw_d = raw_q;
        if (set_we) raw_d = raw_d | set_data;
        if (clr_we) raw_d = raw_d & ~clr_data;
        if (si_hw_set)  raw_d[B_SI]  = 1'b1;
        if (sto_hw_clr) raw_d[B_STO] = 1'b0;
        if (!raw_d[B_EN]) raw_d[B_STO] = 1'b0;
    end

    for (genvar i = 0; i < CTL_W; i++) begin : g_bit
        if (CTL_IMPL[i]) begin : g_store
            always_ff @(posedge clk) begin
                if (rst) raw_q[i] <= 1'b0;
                else     raw_q[i] <= raw_d[i];
            end
        end else begin : g_rsvd
            assign raw_q[i] = 1'b0;
        end
    end

    assign rdata = raw_q;
    assign ctl   = ctl_view(raw_q);

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);

    logic scl_q, sda_q;
    logic start_hit, stop_hit;

    assign start_hit = scl_q & scl_in & sda_q & ~sda_in;
    assign stop_hit  = scl_q & scl_in & ~sda_q & sda_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (!enable)        busy <= 1'b0;
            else if (start_hit) busy <= 1'b1;
            else if (stop_hit)  busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last   = (limit == '0) ? '0 : limit - ONE;
    assign expire = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (restart) cnt <= '0;
        else if (!expire) cnt <= cnt + ONE;
    end

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             bus_busy,
    input  logic [CNT_W-1:0] half_period,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             is_master,
    output logic             si_set,
    output logic             sto_clr
);

    seq_t     st, nxt;
    logic     expire;
    pin_drv_t drv;

    i2c_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (nxt != st),
        .limit   (half_period),
        .expire  (expire)
    );

    always_comb begin
        nxt     = st;
        si_set  = 1'b0;
        sto_clr = 1'b0;
        if (!ctl.en) begin
            nxt = SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (!ctl.si) begin
                        if (ctl.sto)      sto_clr = 1'b1;
                        else if (ctl.sta) nxt = bus_busy ? SQ_WAIT : SQ_START;
                    end
                end
                SQ_WAIT: begin
                    if (!ctl.si && ctl.sto) begin
                        sto_clr = 1'b1;
                        nxt     = SQ_IDLE;
                    end else if (!ctl.sta) nxt = SQ_IDLE;
                    else if (!bus_busy)    nxt = SQ_DELAY;
                end
                SQ_DELAY: begin
                    if (!ctl.si && ctl.sto) begin
                        sto_clr = 1'b1;
                        nxt     = SQ_IDLE;
                    end else if (!ctl.sta) nxt = SQ_IDLE;
                    else if (expire)       nxt = SQ_START;
                end
                SQ_START: begin
                    if (expire) begin
                        nxt    = SQ_OWN;
                        si_set = 1'b1;
                    end
                end
                SQ_OWN: begin
                    if (!ctl.si) begin
                        if (ctl.sto)      nxt = SQ_STP_LO;
                        else if (ctl.sta) nxt = SQ_RS_REL;
                    end
                end
                SQ_RS_REL:  if (expire) nxt = SQ_RS_HI;
                SQ_RS_HI:   if (expire) nxt = SQ_START;
                SQ_STP_LO:  if (expire) nxt = SQ_STP_HI;
                SQ_STP_HI:  if (expire) nxt = SQ_STP_END;
                SQ_STP_END: begin
                    if (expire) begin
                        nxt     = SQ_IDLE;
                        sto_clr = 1'b1;
                    end
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= nxt;
    end

    assign drv       = drive_for(st);
    assign scl_oe    = drv.scl_low;
    assign sda_oe    = drv.sda_low;
    assign is_master = owns_bus(st);

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic [CTL_W-1:0] set_data,
    input  logic             clr_we,
    input  logic [CTL_W-1:0] clr_data,
    input  logic [CNT_W-1:0] half_period,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic [CTL_W-1:0] ctrl_rdata,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             is_master,
    output logic             bus_busy
);

    ctl_t ctl;
    logic si_set, sto_clr;

    i2c_ctl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .set_we     (set_we),
        .set_data   (set_data),
        .clr_we     (clr_we),
        .clr_data   (clr_data),
        .si_hw_set  (si_set),
        .sto_hw_clr (sto_clr),
        .rdata      (ctrl_rdata),
        .ctl        (ctl)
    );

    i2c_bus_watch u_watch (
        .clk    (clk),
        .rst    (rst),
        .enable (ctl.en),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .busy   (bus_busy)
    );

    i2c_cond_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .bus_busy    (bus_busy),
        .half_period (half_period),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .is_master   (is_master),
        .si_set      (si_set),
        .sto_clr     (sto_clr)
    );

endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
module i2c_cond_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       set_we,
    input logic [7:0] set_data,
    input logic       clr_we,
    input logic [7:0] clr_data,
    input logic       scl_in,
    input logic       sda_in,
    input logic [7:0] ctrl_rdata,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       is_master,
    input logic       bus_busy
);

    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_we) |=>
            ((ctrl_rdata & $past(set_data & 8'h6C)) == $past(set_data & 8'h6C)));

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_we && clr_we) |=>
            ((ctrl_rdata & $past(set_data & clr_data & 8'h74)) == 8'h00));

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[6] |=> (!scl_oe && !sda_oe && !is_master && !bus_busy));

    // R6
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[6] && $past(scl_in) && $past(sda_in) && scl_in && !sda_in)
            |=> bus_busy);

    // R6
    free_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[6] && $past(scl_in) && !$past(sda_in) && scl_in && sda_in)
            |=> !bus_busy);

    // R7
    drive_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_oe || sda_oe) |-> is_master);

    // R13
    slave_stop_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[6] && ctrl_rdata[4] && !is_master) |=> !scl_oe);

endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk u_chk (.*);

// File: tb/tb_i2c_cond_ctrl.sv
module tb_i2c_cond_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_we = 1'b0;
    logic [7:0]  set_data = 8'h00;
    logic        clr_we = 1'b0;
    logic [7:0]  clr_data = 8'h00;
    logic [15:0] half_period = 16'd4;
    logic        ext_scl = 1'b0;
    logic        ext_sda = 1'b0;
    logic        scl_in, sda_in;
    logic [7:0]  ctrl_rdata;
    logic        scl_oe, sda_oe, is_master, bus_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    // open-drain bus shared with a scripted second master
    assign scl_in = !(scl_oe || ext_scl);
    assign sda_in = !(sda_oe || ext_sda);

    i2c_cond_ctrl dut (
        .clk(clk), .rst(rst),
        .set_we(set_we), .set_data(set_data),
        .clr_we(clr_we), .clr_data(clr_data),
        .half_period(half_period),
        .scl_in(scl_in), .sda_in(sda_in),
        .ctrl_rdata(ctrl_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .is_master(is_master), .bus_busy(bus_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_set(input logic [7:0] d);
        set_data = d; set_we = 1'b1;
        @(negedge clk);
        set_we = 1'b0; set_data = 8'h00;
    endtask

    task automatic wr_clr(input logic [7:0] d);
        clr_data = d; clr_we = 1'b1;
        @(negedge clk);
        clr_we = 1'b0; clr_data = 8'h00;
    endtask

    task automatic wr_both(input logic [7:0] s, input logic [7:0] c);
        set_data = s; set_we = 1'b1; clr_data = c; clr_we = 1'b1;
        @(negedge clk);
        set_we = 1'b0; clr_we = 1'b0; set_data = 8'h00; clr_data = 8'h00;
    endtask

    task automatic count_start_hold(input string req, input int h);
        int n = 0;
        while (sda_oe && !scl_oe) begin n++; @(negedge clk); end
        chk({req, " start hold length"}, n, h);
        chk({req, " SCL pulled after start"}, scl_oe, 1);
    endtask

    task automatic t_reset;
        // R1
        chk("R1 ctrl byte", ctrl_rdata, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 is_master", is_master, 0);
        chk("R1 bus_busy", bus_busy, 0);
    endtask

    task automatic t_regs;
        wr_set(8'h04);
        chk("R2 set AA", ctrl_rdata, 8'h04);
        wr_set(8'h00);
        chk("R2 zero write keeps", ctrl_rdata, 8'h04);
        wr_set(8'h83);
        chk("R4 reserved stay 0", ctrl_rdata, 8'h04);
        wr_clr(8'h04);
        chk("R3 clear AA", ctrl_rdata, 8'h00);
        wr_both(8'h04, 8'h04);
        chk("R3 clear wins", ctrl_rdata, 8'h00);
    endtask

    task automatic t_disabled;
        ext_sda = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 busy ignored", bus_busy, 0);
        wr_set(8'h20);
        repeat (6) @(negedge clk);
        chk("R5 no SDA drive", sda_oe, 0);
        chk("R5 no SCL drive", scl_oe, 0);
        chk("R5 not master", is_master, 0);
        wr_set(8'h10);
        chk("R5 STO held 0", ctrl_rdata[4], 0);
        ext_sda = 1'b0;
        wr_clr(8'h20);
        chk("R5 STA cleared", ctrl_rdata, 8'h00);
    endtask

    task automatic t_start(input int h);
        wr_set(8'h40);
        chk("R2 enable set", ctrl_rdata, 8'h40);
        wr_set(8'h20);
        chk("R7 no drive in write cycle", sda_oe, 0);
        @(negedge clk);
        chk("R7 SDA pulled 2nd cycle", sda_oe, 1);
        chk("R7 SCL released", scl_oe, 0);
        chk("R7 master", is_master, 1);
        count_start_hold("R7", h);
        chk("R9 SI set", ctrl_rdata[3], 1);
        chk("R6 busy after start", bus_busy, 1);
        wr_set(8'h20);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 hold SCL", scl_oe, 1);
            chk("R9 hold SDA", sda_oe, 0);
        end
    endtask

    task automatic t_rep_start(input int h);
        int n = 0;
        wr_clr(8'h08);
        while (scl_oe) begin
            if (sda_oe) chk("R10 SDA stays released", sda_oe, 0);
            @(negedge clk); n++;
        end
        chk("R10 SCL low phase", n, h + 1);
        n = 0;
        while (!scl_oe && !sda_oe) begin n++; @(negedge clk); end
        chk("R10 released phase", n, h);
        count_start_hold("R10", h);
        chk("R10 SI set again", ctrl_rdata[3], 1);
        chk("R10 busy kept", bus_busy, 1);
    endtask

    task automatic t_stop(input int h);
        int n = 0;
        wr_clr(8'h28);
        wr_set(8'h10);
        @(negedge clk);
        chk("R11 both pulled", {scl_oe, sda_oe}, 3);
        while (scl_oe && sda_oe) begin n++; @(negedge clk); end
        chk("R11 both-low phase", n, h);
        n = 0;
        while (!scl_oe && sda_oe) begin n++; @(negedge clk); end
        chk("R11 SDA-low phase", n, h);
        chk("R11 released", {scl_oe, sda_oe}, 0);
        chk("R11 STO still set", ctrl_rdata[4], 1);
        n = 0;
        while (ctrl_rdata[4]) begin n++; @(negedge clk); end
        chk("R11 STO clear delay", n, h);
        chk("R11 master ends", is_master, 0);
        chk("R6 free after stop", bus_busy, 0);
    endtask

    task automatic t_wait_busy(input int h);
        int n = 0;
        ext_sda = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 busy on ext start", bus_busy, 1);
        ext_scl = 1'b1;
        repeat (2) @(negedge clk);
        wr_set(8'h20);
        repeat (4) @(negedge clk);
        chk("R8 waits no SDA", sda_oe, 0);
        chk("R8 waits not master", is_master, 0);
        ext_scl = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 still busy", bus_busy, 1);
        ext_sda = 1'b0;
        while (!sda_oe) begin
            @(negedge clk); n++;
            if (n == 2) chk("R6 free on ext stop", bus_busy, 0);
        end
        chk("R8 start delay", n, h + 2);
        count_start_hold("R8", h);
        chk("R9 SI after deferred start", ctrl_rdata[3], 1);
    endtask

    task automatic t_stop_start(input int h);
        int n = 0;
        wr_both(8'h10, 8'h08);
        @(negedge clk);
        while (scl_oe && sda_oe) begin n++; @(negedge clk); end
        chk("R12 both-low phase", n, h);
        n = 0;
        while (!scl_oe && sda_oe) begin n++; @(negedge clk); end
        chk("R12 SDA-low phase", n, h);
        n = 0;
        while (!sda_oe) begin @(negedge clk); n++; end
        chk("R12 gap to start", n, h + 1);
        chk("R12 STO cleared", ctrl_rdata[4], 0);
        count_start_hold("R12", h);
        chk("R12 SI set", ctrl_rdata[3], 1);
    endtask

    task automatic t_slave_stop;
        wr_set(8'h30);
        @(negedge clk);
        chk("R13 STO cleared", ctrl_rdata[4], 0);
        chk("R13 no SDA", sda_oe, 0);
        chk("R13 no SCL", scl_oe, 0);
        chk("R13 not master", is_master, 0);
        @(negedge clk);
        chk("R13 start follows", {scl_oe, sda_oe}, 1);
        while (!scl_oe) @(negedge clk);
        chk("R13 SI after start", ctrl_rdata[3], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled();
        t_start(4);
        t_rep_start(4);
        t_stop(4);
        half_period = 16'd3;
        t_wait_busy(3);
        t_stop_start(3);
        t_stop(3);
        t_slave_stop();
        t_stop(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #600us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule